// File: doc/BRIEF.md
# Burst SPI Master with Sticky Events

This block is a register-programmed SPI master that moves a whole buffer per start command. Software writes up to 64 characters into a transmit buffer, writes the character count, arms the receive buffer and writes the start bit. The block then shifts each character out on `mosi` and captures the incoming bit stream into a receive buffer at the same index. When the last character completes, it raises two completion events.

The serial clock is generated from the system clock by a programmable prescaler. Clock idle level, sampling phase, bit order and character length (1 to 16 bits) come from one mode register. A loopback bit routes the outgoing stream back into the receiver. Several conditions refuse a start, and each records its own error event. These are a start during a burst, a start while the receive buffer is not armed, and a start with the master bit clear. All events are sticky and write-one-to-clear. A mask register selects which events drive the level interrupt.

Register map (word addresses): mode 0x00, command 0x01, events 0x02, mask 0x03, transmit count 0x04, received count 0x05, receive-armed flag 0x06. Address 0x40+i writes transmit entry i and reads receive entry i.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the mode, event, mask, count and received-count registers read 0, the receive-armed flag reads 0, and `sclk`, `mosi` and `irq` are low.
- R2: A start (command bit 7 written as 1) with enable, master and armed set and a count N > 0 sends transmit entries 0..N-1 in order and stores each received character at the same receive index. At the end the received count reads N and event bits 0 (receive done) and 1 (transmit done) are set.
- R3: Each `sclk` half period lasts (P+1) system clocks, where P is mode bits 3:0. It lasts 16 times that when mode bit 11 is set. A burst makes exactly 2·L·N clock edges, and outside a burst `sclk` rests at the level in mode bit 13.
- R4: With mode bit 12 clear, the data bit is valid before the leading edge of each bit and sampled on it. With bit 12 set, it is sampled on the trailing edge.
- R5: Mode bits 7:4 hold L-1 for a character length L of 1..16. Mode bit 10 set sends and receives the most significant bit first, and clear sends the least significant bit first. Unused upper bits of a received entry read 0.
- R6: With mode bit 14 set the receiver takes the outgoing `mosi` stream; otherwise it takes `miso`.
- R7: A start during a burst is ignored and sets event bit 4; the burst in progress completes unchanged.
- R8: Writing 1 to bit 0 of address 0x06 arms the receive buffer, and any start that runs clears it. A start while it is not armed sets event bit 2 and does not run.
- R9: A start with mode bit 8 (enable) clear has no effect. A start with bit 8 set and bit 9 (master) clear sets event bit 5 and does not run.
- R10: A start with count 0 runs nothing, sets event bits 0 and 1 on the next clock, sets the received count to 0 and clears the armed flag.
- R11: Event bits are sticky. Writing 1 to a bit of address 0x02 clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R12: `irq` is high exactly when some event bit is set whose bit in the mask register (same layout) is also set.
- R13: A count write above 64 stores 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register or buffer write strobe |
| addr | input | 7 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out, low when idle |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt (level) |

## Verification
The bench sweeps all four polarity/phase pairs, both bit orders, lengths of 1, 5, 8, 12 and 16, both prescaler paths, and a full 64-entry burst. It rebuilds every transmitted word from `mosi` at the sampling edges. A phase error would shift each word by one bit, and a wrong boundary between characters would corrupt the last bit. With `miso` tied to the inverse of `mosi`, a broken loopback select gives complemented data. The refusal cases are driven separately: a second start mid-burst, a start while unarmed, a start while not master, a start while disabled and a zero count. A design that lets any of them start would show clock edges or a changed armed flag, and a design that corrupts an active burst would show a wrong edge count.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int CHAR_W = 16;
  localparam int LEN_W  = 5;
  localparam int HP_W   = 9;
  localparam int EV_W   = 6;

  localparam int REG_MODE  = 0;
  localparam int REG_CMD   = 1;
  localparam int REG_EVT   = 2;
  localparam int REG_MASK  = 3;
  localparam int REG_TXCNT = 4;
  localparam int REG_RXCNT = 5;
  localparam int REG_ARM   = 6;

  localparam int CMD_GO = 7;

  localparam int MB_LOOP = 14;
  localparam int MB_CPOL = 13;
  localparam int MB_CPHA = 12;
  localparam int MB_DIV  = 11;
  localparam int MB_MSB  = 10;
  localparam int MB_MST  = 9;
  localparam int MB_EN   = 8;

  localparam int EV_RXD = 0;
  localparam int EV_TXD = 1;
  localparam int EV_BSY = 2;
  localparam int EV_TXE = 4;
  localparam int EV_MME = 5;

  // system clocks per serial half period
  function automatic logic [HP_W-1:0] half_period(input logic [3:0] pm, input logic div16);
    logic [HP_W-1:0] base;
    base = {{(HP_W-4){1'b0}}, pm} + 1'b1;
    return div16 ? (base << 4) : base;
  endfunction

  // physical bit index of the k-th bit on the wire
  function automatic logic [LEN_W-1:0] wire_bit(input logic [LEN_W-1:0] k,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic msb_first);
    return msb_first ? (len - 1'b1 - k) : k;
  endfunction
endpackage

// File: rtl/spi_burst_clkgen.sv
module spi_burst_clkgen
  import spi_burst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] half_len,
  output logic            edge_o,
  output logic            phase_o
);
  logic [HP_W-1:0] hcnt_q;

  assign edge_o = run && (hcnt_q == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hcnt_q  <= '0;
      phase_o <= 1'b0;
    end else if (edge_o) begin
      hcnt_q  <= '0;
      phase_o <= ~phase_o;
    end else begin
      hcnt_q  <= hcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_word,
  input  logic              edge_i,
  input  logic              cpha,
  input  logic              msb_first,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              din,
  output logic              mosi_o,
  output logic              char_done,
  output logic [CHAR_W-1:0] rx_word_o
);
  logic [LEN_W:0]    eidx_q;
  logic [LEN_W-1:0]  tk_q;
  logic [CHAR_W-1:0] tx_q, rx_q;
  logic              samp, last_edge, shift;

  assign last_edge = (eidx_q == {char_len, 1'b0} - 1'b1);
  assign samp      = (eidx_q[0] == cpha);
  assign shift     = !samp && (eidx_q != '0) && !last_edge;
  assign char_done = edge_i && last_edge;
  assign mosi_o    = tx_q[wire_bit(tk_q, char_len, msb_first)];

  always_comb begin
    rx_word_o = rx_q;
    if (edge_i && samp)
      rx_word_o[wire_bit(eidx_q[LEN_W:1], char_len, msb_first)] = din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eidx_q <= '0;
      tk_q   <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (load) begin
      eidx_q <= '0;
      tk_q   <= '0;
      tx_q   <= load_word;
      rx_q   <= '0;
    end else if (edge_i) begin
      eidx_q <= eidx_q + 1'b1;
      rx_q   <= rx_word_o;
      if (shift) tk_q <= tk_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_burst_events.sv
module spi_burst_events
  import spi_burst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] set_i,
  input  logic [EV_W-1:0] clr_i,
  input  logic [EV_W-1:0] mask_i,
  output logic [EV_W-1:0] ev_o,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) ev_o <= '0;
    else        ev_o <= (ev_o & ~clr_i) | set_i;
  end

  assign irq_o = |(ev_o & mask_i);
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter  int DEPTH  = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic [14:0]       mode_q;
  logic [EV_W-1:0]   mask_q, ev_q, ev_set, ev_clr;
  logic [CNT_W-1:0]  cnt_q, rxcnt_q, cidx_q;
  logic              armed_q, active_q;
  logic [CHAR_W-1:0] tx_mem [DEPTH];
  logic [CHAR_W-1:0] rx_mem [DEPTH];

  // named internal events, observed by the checker
  logic start_req, go_ok, launch, instant, last_char, finish;
  logic edge_pulse, sck_phase, char_done, mosi_int, din, load;
  logic cfg_en, cfg_master, cfg_cpol;
  logic [CHAR_W-1:0] rx_word, load_word;
  logic [IDX_W-1:0]  next_idx;
  logic [LEN_W-1:0]  char_len;

  logic sel_buf;
  assign sel_buf = addr[ADDR_W-1];

  function automatic logic reg_hit(input logic [ADDR_W-1:0] a, input int r);
    return !a[ADDR_W-1] && (a == ADDR_W'(r));
  endfunction

  assign cfg_en     = mode_q[MB_EN];
  assign cfg_master = mode_q[MB_MST];
  assign cfg_cpol   = mode_q[MB_CPOL];
  assign char_len   = {1'b0, mode_q[7:4]} + 1'b1;

  assign start_req = wr_en && reg_hit(addr, REG_CMD) && wdata[CMD_GO];
  assign go_ok     = start_req && cfg_en && !active_q && cfg_master && armed_q;
  assign launch    = go_ok && (cnt_q != '0);
  assign instant   = go_ok && (cnt_q == '0);
  assign last_char = (cidx_q == cnt_q - 1'b1);
  assign finish    = char_done && last_char;
  assign next_idx  = IDX_W'(cidx_q + 1'b1);
  assign load      = launch || (char_done && !last_char);
  assign load_word = launch ? tx_mem[0] : tx_mem[next_idx];

  always_comb begin
    ev_set         = '0;
    ev_set[EV_RXD] = finish || instant;
    ev_set[EV_TXD] = finish || instant;
    ev_set[EV_BSY] = start_req && cfg_en && !active_q && cfg_master && !armed_q;
    ev_set[EV_TXE] = start_req && cfg_en && active_q;
    ev_set[EV_MME] = start_req && cfg_en && !active_q && !cfg_master;
  end

  assign ev_clr = (wr_en && reg_hit(addr, REG_EVT)) ? wdata[EV_W-1:0] : '0;

  spi_burst_clkgen u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active_q),
    .half_len (half_period(mode_q[3:0], mode_q[MB_DIV])),
    .edge_o   (edge_pulse),
    .phase_o  (sck_phase)
  );

  assign din = mode_q[MB_LOOP] ? mosi_int : miso;

  spi_burst_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .edge_i    (edge_pulse),
    .cpha      (mode_q[MB_CPHA]),
    .msb_first (mode_q[MB_MSB]),
    .char_len  (char_len),
    .din       (din),
    .mosi_o    (mosi_int),
    .char_done (char_done),
    .rx_word_o (rx_word)
  );

  spi_burst_events u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_set),
    .clr_i  (ev_clr),
    .mask_i (mask_q),
    .ev_o   (ev_q),
    .irq_o  (irq)
  );

  assign sclk = active_q ? (sck_phase ^ cfg_cpol) : cfg_cpol;
  assign mosi = active_q && mosi_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      rxcnt_q  <= '0;
      cidx_q   <= '0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (wr_en && reg_hit(addr, REG_MODE))  mode_q <= wdata[14:0];
      if (wr_en && reg_hit(addr, REG_MASK))  mask_q <= wdata[EV_W-1:0];
      if (wr_en && reg_hit(addr, REG_TXCNT))
        cnt_q <= (wdata > 16'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(wdata);
      if (wr_en && reg_hit(addr, REG_ARM) && wdata[0]) armed_q <= 1'b1;
      if (go_ok) armed_q <= 1'b0;
      if (launch) begin
        active_q <= 1'b1;
        cidx_q   <= '0;
      end else if (finish) begin
        active_q <= 1'b0;
        rxcnt_q  <= cnt_q;
      end else if (char_done) begin
        cidx_q   <= cidx_q + 1'b1;
      end
      if (instant) rxcnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && sel_buf) tx_mem[addr[IDX_W-1:0]] <= wdata;
    if (char_done)        rx_mem[cidx_q[IDX_W-1:0]] <= rx_word;
  end

  always_comb begin
    rdata = '0;
    if (sel_buf) rdata = rx_mem[addr[IDX_W-1:0]];
    else if (reg_hit(addr, REG_MODE))  rdata = {1'b0, mode_q};
    else if (reg_hit(addr, REG_EVT))   rdata = 16'(ev_q);
    else if (reg_hit(addr, REG_MASK))  rdata = 16'(mask_q);
    else if (reg_hit(addr, REG_TXCNT)) rdata = 16'(cnt_q);
    else if (reg_hit(addr, REG_RXCNT)) rdata = 16'(rxcnt_q);
    else if (reg_hit(addr, REG_ARM))   rdata = 16'(armed_q);
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk
  import spi_burst_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             start_req,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             edge_pulse,
  input logic             sclk,
  input logic             cpol,
  input logic             en,
  input logic             master,
  input logic [EV_W-1:0]  ev,
  input logic [EV_W-1:0]  ev_clr
);
  a_r13_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == cpol));

  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !edge_pulse) |=> $stable(sclk));

  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && en && active && !edge_pulse) |=> (active && ev[EV_TXE]));

  a_r8_unarmed_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && en && master && !active && !armed) |=> (!active && ev[EV_BSY]));

  a_r9_not_master_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && en && !master && !active) |=> (!active && ev[EV_MME]));

  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && en && master && !active && armed && cnt == '0)
      |=> (!active && ev[EV_RXD] && ev[EV_TXD] && !armed));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev & $past(ev & ~ev_clr)) == $past(ev & ~ev_clr)));
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active_q),
  .start_req  (start_req),
  .armed      (armed_q),
  .cnt        (cnt_q),
  .edge_pulse (edge_pulse),
  .sclk       (sclk),
  .cpol       (cfg_cpol),
  .en         (cfg_en),
  .master     (cfg_master),
  .ev         (ev_q),
  .ev_clr     (ev_clr)
);

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi, miso, irq;

  always #10 clk = ~clk;
  assign miso = ~mosi;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  typedef struct packed {
    logic loop; logic cpol; logic cpha; logic msb; logic d16;
    logic [3:0] pm; logic [4:0] len; logic [6:0] cnt; logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 5'd8,  7'd4,  8'h3C},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 5'd8,  7'd3,  8'h51},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 5'd8,  7'd2,  8'hA7},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 5'd5,  7'd5,  8'h19},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 5'd16, 7'd1,  8'hE2},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 5'd12, 7'd3,  8'h6D},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 5'd1,  7'd6,  8'h0F},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 5'd8,  7'd64, 8'hC3}
  };

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    wr_en = 1'b0; addr = 7'(a);
    #1 d = int'(rdata);
  endtask

  function automatic logic [15:0] lmask(input int len);
    return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
  endfunction

  function automatic logic [15:0] pat(input logic [7:0] seed, input int i, input int len);
    return ({seed, ~seed} ^ 16'(i * 12059 + i)) & lmask(len);
  endfunction

  function automatic int hp(input int pm, input bit d16);
    return (pm + 1) * (d16 ? 16 : 1);
  endfunction

  // line monitor: rebuilds words from mosi at sampling edges
  int cyc = 0, mon_edges = 0, mon_last = 0, gmin = 0, gmax = 0;
  int m_cpha = 0, m_len = 8, m_msb = 1;
  bit mon_en = 0;
  logic mon_prev_sclk = 1'b0, mon_prev_mosi = 1'b0;
  logic [15:0] mon_word [64];

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (sclk !== mon_prev_sclk) begin
        if (mon_edges > 0) begin
          if (cyc - mon_last < gmin) gmin = cyc - mon_last;
          if (cyc - mon_last > gmax) gmax = cyc - mon_last;
        end
        mon_last = cyc;
        if ((mon_edges % 2) == m_cpha) begin
          if (mon_edges / (2 * m_len) < 64) begin
            if (m_msb != 0)
              mon_word[mon_edges / (2 * m_len)][m_len - 1 - (mon_edges / 2) % m_len] = mon_prev_mosi;
            else
              mon_word[mon_edges / (2 * m_len)][(mon_edges / 2) % m_len] = mon_prev_mosi;
          end
        end
        mon_edges++;
      end
      mon_prev_sclk = sclk;
      mon_prev_mosi = mosi;
    end
  end

  task automatic mon_reset(input int cpha, input int len, input int msb);
    @(negedge clk); #1;
    m_cpha = cpha; m_len = len; m_msb = msb;
    mon_edges = 0; gmin = 1000000; gmax = 0;
    mon_prev_sclk = sclk; mon_prev_mosi = mosi;
    for (int i = 0; i < 64; i++) mon_word[i] = '0;
    mon_en = 1;
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    while (irq !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(req, "completion interrupt", int'(irq === 1'b1), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int d, len, cnt, modew, expw;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d); check("R1", "mode", d, 0);
    rd(2, d); check("R1", "events", d, 0);
    rd(3, d); check("R1", "mask", d, 0);
    rd(4, d); check("R1", "count", d, 0);
    rd(5, d); check("R1", "rx count", d, 0);
    rd(6, d); check("R1", "armed", d, 0);
    check("R1", "sclk/mosi/irq", int'({sclk, mosi, irq}), 0);

    // R13 saturation
    wr(4, 100); rd(4, d); check("R13", "count saturates", d, 64);

    // table-driven bursts
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      len = int'(v.len); cnt = int'(v.cnt);
      modew = (int'(v.loop) << 14) | (int'(v.cpol) << 13) | (int'(v.cpha) << 12) |
              (int'(v.d16) << 11) | (int'(v.msb) << 10) | 16'h0300 |
              ((len - 1) << 4) | int'(v.pm);
      wr(0, modew);
      wr(4, cnt);
      for (int i = 0; i < cnt; i++) wr(64 + i, int'(pat(v.seed, i, len)));
      wr(2, 16'h3F);
      wr(3, 3);
      wr(6, 1);
      mon_reset(int'(v.cpha), len, int'(v.msb));
      wr(1, 16'h80);
      wait_irq("R2");
      repeat (2) @(negedge clk);
      mon_en = 0;
      for (int i = 0; i < cnt; i++) begin
        rd(64 + i, d);
        expw = v.loop ? int'(pat(v.seed, i, len)) : int'(~pat(v.seed, i, len) & lmask(len));
        check(v.loop ? "R6 loopback R2" : "R6 miso R2", "rx entry", d, expw);
        check(v.msb ? "R4 R5 msb-first" : "R4 R5 lsb-first", "mosi word", int'(mon_word[i]),
              int'(pat(v.seed, i, len)));
      end
      check("R3", "edge count", mon_edges, 2 * len * cnt);
      check("R3", "min half period", gmin, hp(int'(v.pm), v.d16));
      check("R3", "max half period", gmax, hp(int'(v.pm), v.d16));
      check("R3", "idle level", int'(sclk), int'(v.cpol));
      rd(5, d); check("R2", "rx count", d, cnt);
      rd(2, d); check("R2", "done events", d, 3);
      rd(6, d); check("R8", "armed cleared by burst", d, 0);
    end

    // R8 start while not armed
    wr(0, 16'h0370); wr(4, 2); wr(2, 16'h3F); wr(3, 0);
    mon_reset(0, 8, 1);
    wr(1, 16'h80);
    repeat (20) @(negedge clk);
    rd(2, d); check("R8", "busy event", d, 16'h04);
    check("R8", "no clock edges", mon_edges, 0);

    // R9 enable clear: no effect
    wr(6, 1); wr(2, 16'h3F); wr(0, 16'h0270);
    mon_reset(0, 8, 1);
    wr(1, 16'h80);
    repeat (20) @(negedge clk);
    rd(2, d); check("R9", "disabled start events", d, 0);
    check("R9", "disabled no edges", mon_edges, 0);
    rd(6, d); check("R9", "disabled keeps armed", d, 1);

    // R9 master clear
    wr(0, 16'h0170);
    mon_reset(0, 8, 1);
    wr(1, 16'h80);
    repeat (20) @(negedge clk);
    rd(2, d); check("R9", "not-master event", d, 16'h20);
    check("R9", "not-master no edges", mon_edges, 0);
    rd(6, d); check("R9", "not-master keeps armed", d, 1);

    // R10 zero count
    wr(0, 16'h0370); wr(4, 0); wr(2, 16'h3F);
    wr(1, 16'h80);
    rd(2, d); check("R10", "zero count events", d, 3);
    rd(5, d); check("R10", "zero rx count", d, 0);
    rd(6, d); check("R10", "zero count disarms", d, 0);

    // R7 start during a burst
    wr(0, 16'h4771); wr(4, 4);
    for (int i = 0; i < 4; i++) wr(64 + i, 16'hA0 + i * 7);
    wr(2, 16'h3F); wr(3, 3); wr(6, 1);
    mon_reset(0, 8, 1);
    wr(1, 16'h80);
    repeat (10) @(negedge clk);
    wr(1, 16'h80);
    rd(2, d); check("R7", "transmit error while running", d, 16'h10);
    wait_irq("R7");
    repeat (2) @(negedge clk);
    mon_en = 0;
    check("R7", "burst edges unchanged", mon_edges, 64);
    for (int i = 0; i < 4; i++) begin
      rd(64 + i, d); check("R7", "burst data intact", d, 16'hA0 + i * 7);
    end

    // R11 write-one-to-clear
    rd(2, d); check("R11", "events before clear", d, 16'h13);
    wr(2, 0);     rd(2, d); check("R11", "zero write keeps", d, 16'h13);
    wr(2, 16'h10); rd(2, d); check("R11", "clear bit 4", d, 16'h03);
    wr(2, 16'h01); rd(2, d); check("R11", "clear bit 0", d, 16'h02);

    // R12 masking
    wr(3, 0);     #1 check("R12", "irq masked", int'(irq), 0);
    wr(3, 16'h02); #1 check("R12", "irq enabled", int'(irq), 1);
    wr(3, 16'h01); #1 check("R12", "irq other bit", int'(irq), 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule